// File: doc/BRIEF.md
# Gated Multi-Oscillator Counter Bank

This block is an on-chip sensor monitor made of many event counters. Each channel counter is clocked by its own free-running ring oscillator. The oscillators differ in frequency and drift with temperature and ageing, so no two channel domains share any phase or frequency relation. A shared gate input opens one counting window of known length for all channels at once. The count each channel reaches over that window is therefore a measure of its oscillator's speed.

A readout engine runs on a separate low-speed clock. After an accepted start request, the engine clears every counter through a handshake into each oscillator domain and then arms the bank. It waits for the gate to open and close. It then collects the channels one at a time, lowest index first, and presents each one as a word on a valid/ready output.

A channel's count is sampled only once that channel has signalled, through a synchroniser, that its counter has stopped. The count is then a held value when it crosses into the readout domain. The gate reaches each oscillator domain through a multi-flop synchroniser. The gate is combined with an armed level from the readout engine, so gate activity outside an armed window has no effect on the counters.

Top module: `osc_counter_bank`

## Requirements
- R1: After reset, `out_valid` and `done_o` are low and every channel count and overflow flag is zero.
- R2: Within an armed window, each channel's count equals the number of rising edges of that channel's oscillator at which `gate_i` was high, provided the gate never changes exactly on an oscillator edge.
- R3: A count never wraps. It stops at 2^CW-1, and the channel's overflow flag is set exactly when more than 2^CW-1 edges fell inside the window. Once set, the flag stays set until the next clear.
- R4: A start pulse is accepted only while the engine is idle or done and the synchronised gate is low. An accepted start clears all counts and overflow flags before arming. A start given while the gate is high is ignored, and a gate window with no accepted start counts nothing.
- R5: After the gate closes, the engine emits one word per channel in index order 0 up to NCH-1. It samples a channel only after that channel's stopped acknowledge has been synchronised into the readout domain. Word layout: bits [CW+IW:CW+1] hold the channel index (IW = clog2(NCH)), bit [CW] holds the overflow flag, and bits [CW-1:0] hold the count.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. Each cycle with both high transfers exactly one word.
- R7: `done_o` rises on the readout clock edge that follows the handshake of the last channel's word. It stays high until the next accepted start.
- R8: Once the window has closed, the gate is ignored until `done_o` is high, and also while `done_o` is high: counts do not change and no extra words appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| osc_clk | input | NCH | One free-running oscillator clock per channel |
| gate_i | input | 1 | Shared counting window, asynchronous to every clock |
| rd_clk | input | 1 | Slow readout clock |
| start_i | input | 1 | Request to clear and arm the bank (rd_clk domain) |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_valid | output | 1 | A channel word is presented |
| out_data | output | clog2(NCH)+1+CW | Channel index, overflow flag and count |
| done_o | output | 1 | All channel words of this window have been taken |

## Verification
The expected word for each channel is computed when the bench drops the gate. By then every counted edge has happened. The first word can only appear later, after two synchroniser paths (the gate into the readout domain, and the stopped acknowledge back out of the channel domain). Words are therefore compared in handshake order against a queue, whatever cycle they arrive in.

The bench samples outputs on the falling readout edge. `done_o` is due exactly one readout cycle after the final handshake, so it is checked on the next falling edge. The hold rule is checked on every stalled cycle. A gate pulse that must be ignored is followed by a wait longer than every synchroniser path before the outputs are examined.

// File: rtl/ocb_pkg.sv
package ocb_pkg;
   typedef enum logic [2:0] {
      RD_IDLE,
      RD_CLR,
      RD_REL,
      RD_ARMED,
      RD_COUNT,
      RD_WAIT,
      RD_SEND,
      RD_DONE
   } rd_state_t;
endpackage

// File: rtl/ocb_sync.sv
module ocb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ocb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/ocb_channel.sv
module ocb_channel #(
   parameter int CW     = 16,
   parameter int STAGES = 2
) (
   input  logic          osc_clk,
   input  logic          rst_n,
   input  logic          gate_en,
   input  logic          clr_req,
   output logic [CW-1:0] cnt_o,
   output logic          ovf_o,
   output logic          stopped_o,
   output logic          clr_ack_o
);
   localparam logic [CW-1:0] MAXV = {CW{1'b1}};

   logic gate_s, clr_s;

   ocb_sync #(.STAGES(STAGES)) u_gate_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(gate_en), .q(gate_s));
   ocb_sync #(.STAGES(STAGES)) u_clr_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(clr_req), .q(clr_s));

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o     <= '0;
         ovf_o     <= 1'b0;
         stopped_o <= 1'b1;
      end else begin
         stopped_o <= ~gate_s;
         if (clr_s) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
         end else if (gate_s) begin
            if (cnt_o == MAXV) ovf_o <= 1'b1;
            else               cnt_o <= cnt_o + 1'b1;
         end
      end
   end

   assign clr_ack_o = clr_s;

   AST_SAT_HOLD: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (cnt_o == MAXV && !clr_s) |=> (cnt_o == MAXV)); // R3
   AST_OVF_STICKY: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (ovf_o && !clr_s) |=> ovf_o); // R3
   AST_FROZEN_WHEN_STOPPED: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (stopped_o && !gate_s && !clr_s) |=> $stable(cnt_o)); // R2
endmodule

// File: rtl/ocb_readout.sv
module ocb_readout
   import ocb_pkg::*;
#(
   parameter int NCH    = 32,
   parameter int CW     = 16,
   parameter int STAGES = 2,
   localparam int IW    = $clog2(NCH),
   localparam int WW    = IW + 1 + CW
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              gate_i,
   input  logic              start_i,
   input  logic [NCH*CW-1:0] cnt_flat,
   input  logic [NCH-1:0]    ovf_v,
   input  logic [NCH-1:0]    stop_v,
   input  logic [NCH-1:0]    ack_v,
   output logic              clr_req_o,
   output logic              win_en_o,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WW-1:0]     out_data,
   output logic              done_o
);
   localparam logic [IW-1:0] LAST = IW'(NCH - 1);

   rd_state_t      state;
   logic [IW-1:0]  idx;
   logic           gate_rs;
   logic [NCH-1:0] stop_s, ack_s;

   ocb_sync #(.STAGES(STAGES)) u_gate_rd (
      .clk(rd_clk), .rst_n(rst_n), .d(gate_i), .q(gate_rs));

   for (genvar c = 0; c < NCH; c++) begin : g_back
      ocb_sync #(.STAGES(STAGES)) u_stop (
         .clk(rd_clk), .rst_n(rst_n), .d(stop_v[c]), .q(stop_s[c]));
      ocb_sync #(.STAGES(STAGES)) u_ack (
         .clk(rd_clk), .rst_n(rst_n), .d(ack_v[c]), .q(ack_s[c]));
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RD_IDLE;
         idx       <= '0;
         clr_req_o <= 1'b0;
         win_en_o  <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         unique case (state)
            RD_IDLE, RD_DONE: if (start_i && !gate_rs) begin
               clr_req_o <= 1'b1;
               state     <= RD_CLR;
            end
            RD_CLR: if (&ack_s) begin
               clr_req_o <= 1'b0;
               state     <= RD_REL;
            end
            RD_REL: if (~|ack_s) begin
               win_en_o <= 1'b1;
               state    <= RD_ARMED;
            end
            RD_ARMED: if (gate_rs) state <= RD_COUNT;
            RD_COUNT: if (!gate_rs) begin
               win_en_o <= 1'b0;
               idx      <= '0;
               state    <= RD_WAIT;
            end
            RD_WAIT: if (stop_s[idx]) begin
               out_data  <= {idx, ovf_v[idx], cnt_flat[idx*CW +: CW]};
               out_valid <= 1'b1;
               state     <= RD_SEND;
            end
            RD_SEND: if (out_ready) begin
               out_valid <= 1'b0;
               if (idx == LAST) state <= RD_DONE;
               else begin
                  idx   <= idx + 1'b1;
                  state <= RD_WAIT;
               end
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

   assign done_o = (state == RD_DONE);

   AST_HOLD_WORD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
   AST_IDX_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (out_valid && out_ready && idx != LAST) |=> (idx == IW'($past(idx) + 1'b1))); // R5
   AST_SAMPLE_STOPPED: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $rose(out_valid) |-> stop_s[idx]); // R5
   AST_DONE_LAST: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (out_valid && out_ready && idx == LAST) |=> done_o); // R7
   AST_READ_CLOSED: assert property (@(posedge rd_clk) disable iff (!rst_n)
      out_valid |-> !win_en_o); // R8
endmodule

// File: rtl/osc_counter_bank.sv
module osc_counter_bank #(
   parameter int NCH         = 32,
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      rst_n,
   input  logic [NCH-1:0]            osc_clk,
   input  logic                      gate_i,
   input  logic                      rd_clk,
   input  logic                      start_i,
   input  logic                      out_ready,
   output logic                      out_valid,
   output logic [$clog2(NCH)+CW:0]   out_data,
   output logic                      done_o
);
   if (NCH < 2) begin : g_bad_nch
      $error("osc_counter_bank: NCH must be at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("osc_counter_bank: CW must be at least 2");
   end

   logic [NCH*CW-1:0] cnt_flat;
   logic [NCH-1:0]    ovf_v, stop_v, ack_v;
   logic              clr_req, win_en, gate_en;

   // Window level only changes while the gate is low, so the AND is glitch-free
   assign gate_en = gate_i & win_en;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ocb_channel #(.CW(CW), .STAGES(SYNC_STAGES)) u_ch (
         .osc_clk   (osc_clk[c]),
         .rst_n     (rst_n),
         .gate_en   (gate_en),
         .clr_req   (clr_req),
         .cnt_o     (cnt_flat[c*CW +: CW]),
         .ovf_o     (ovf_v[c]),
         .stopped_o (stop_v[c]),
         .clr_ack_o (ack_v[c])
      );
   end

   ocb_readout #(.NCH(NCH), .CW(CW), .STAGES(SYNC_STAGES)) u_rd (
      .rd_clk    (rd_clk),
      .rst_n     (rst_n),
      .gate_i    (gate_i),
      .start_i   (start_i),
      .cnt_flat  (cnt_flat),
      .ovf_v     (ovf_v),
      .stop_v    (stop_v),
      .ack_v     (ack_v),
      .clr_req_o (clr_req),
      .win_en_o  (win_en),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .done_o    (done_o)
   );
endmodule

// File: tb/osc_counter_bank_tb.sv
module osc_counter_bank_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NCH  = 32;
   localparam int CW   = 8;
   localparam int IW   = $clog2(NCH);
   localparam int WW   = IW + 1 + CW;
   localparam int MAXV = (1 << CW) - 1;

   logic           rst_n = 1'b0;
   logic [NCH-1:0] osc_clk;
   logic           gate_i = 1'b0;
   logic           rd_clk = 1'b0;
   logic           start_i = 1'b0;
   logic           out_ready = 1'b0;
   logic           out_valid;
   logic [WW-1:0]  out_data;
   logic           done_o;

   int  errors = 0;
   int  checks = 0;
   bit  live = 1'b0;
   bit  bclr = 1'b0;
   int  ecnt [NCH];
   logic [WW-1:0] exp_q [$];

   osc_counter_bank #(.NCH(NCH), .CW(CW), .SYNC_STAGES(2)) u_dut (
      .rst_n(rst_n), .osc_clk(osc_clk), .gate_i(gate_i), .rd_clk(rd_clk),
      .start_i(start_i), .out_ready(out_ready), .out_valid(out_valid),
      .out_data(out_data), .done_o(done_o));

   always #4 rd_clk = ~rd_clk;

   // Oscillator models: edges land on even picoseconds, gate changes on odd ones
   for (genvar g = 0; g < NCH; g++) begin : g_osc
      logic ck = 1'b0;
      int   n  = 0;
      initial begin
         #((6.0 * g) / 1000.0);
         forever #((1500.0 + 40.0 * g) / 1000.0) ck = ~ck;
      end
      assign osc_clk[g] = ck;
      assign ecnt[g]    = n;
      always @(posedge ck) begin
         if (bclr)                n <= 0;
         else if (gate_i && live) n <= n + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   // Monitor: drives ready, pops the scoreboard on each handshake
   int  cyc = 0;
   bit  prev_stall = 1'b0;
   bit  done_due = 1'b0;
   logic [WW-1:0] prev_data = '0;
   always @(negedge rd_clk) begin
      logic [WW-1:0] e;
      bit rdy;
      if (rst_n) begin
         cyc++;
         if (prev_stall)
            check(out_valid && out_data == prev_data, "R6 hold", int'(out_data), int'(prev_data));
         if (done_due) begin
            check(done_o == 1'b1, "R7 done after last word", int'(done_o), 1);
            done_due = 1'b0;
         end
         rdy = (cyc % 4) != 1;
         out_ready = rdy;
         if (out_valid && rdy) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected word", int'(out_data), 0);
            end else begin
               e = exp_q.pop_front();
               check(out_data[WW-1:CW+1] == e[WW-1:CW+1], "R5 index order",
                     int'(out_data[WW-1:CW+1]), int'(e[WW-1:CW+1]));
               check(out_data[CW:0] == e[CW:0], e[CW] ? "R3 saturated count" : "R2 count",
                     int'(out_data[CW:0]), int'(e[CW:0]));
               if (e[WW-1:CW+1] == IW'(NCH - 1)) done_due = 1'b1;
            end
         end
         prev_stall = out_valid && !rdy;
         prev_data  = out_data;
      end
   end

   task automatic run_window(input int len, input bit extra_pulse);
      int n;
      cycles(1);
      start_i = 1'b1;
      cycles(1);
      start_i = 1'b0;
      bclr = 1'b1;
      cycles(40);
      bclr = 1'b0;
      live = 1'b1;
      cycles(2);
      #0.001 gate_i = 1'b1;
      cycles(len);
      #0.001 gate_i = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         n = ecnt[c];
         exp_q.push_back({IW'(c), (n > MAXV), CW'((n > MAXV) ? MAXV : n)});
      end
      live = 1'b0;
      if (extra_pulse) begin
         cycles(6);
         #0.001 gate_i = 1'b1;
         cycles(10);
         #0.001 gate_i = 1'b0;
      end
      for (int w = 0; w < 5000; w++) begin
         if (done_o && exp_q.size() == 0) break;
         cycles(1);
      end
      cycles(1);
      check(exp_q.size() == 0, "R5 all channels read", exp_q.size(), 0);
      check(done_o == 1'b1, "R7 done held", int'(done_o), 1);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      cycles(10);
      rst_n = 1'b1;
      cycles(1);
      check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);

      // R4: a gate window before any accepted start produces nothing
      #0.001 gate_i = 1'b1;
      cycles(20);
      #0.001 gate_i = 1'b0;
      cycles(40);
      check(out_valid == 1'b0 && done_o == 1'b0, "R4 gate without start", int'(out_valid), 0);

      run_window(75, 1'b0);   // mid-range counts
      run_window(150, 1'b1);  // some channels saturate; R8 pulse during readout

      // R8: gate pulse after done changes nothing
      #0.001 gate_i = 1'b1;
      cycles(20);
      #0.001 gate_i = 1'b0;
      cycles(40);
      check(done_o == 1'b1 && out_valid == 1'b0, "R8 gate after done", int'(out_valid), 0);

      // R4: start while gate high is ignored
      #0.001 gate_i = 1'b1;
      cycles(4);
      start_i = 1'b1;
      cycles(1);
      start_i = 1'b0;
      cycles(4);
      #0.001 gate_i = 1'b0;
      cycles(40);
      check(done_o == 1'b1, "R4 start with gate high", int'(done_o), 1);

      run_window(6, 1'b0);    // short window, counts restart from zero (R4 clear)

      cycles(5);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule